// File: doc/BRIEF.md
# Selectable Pseudo-Random Test Pattern Source

This block emits one serial test bit per enabled clock cycle. A 3-bit mode input picks the bit stream: three maximal-length pseudo-random sequences of different lengths, a zero-limited variant of the 20-stage sequence, an alternating pattern, a steady-one pattern, or a 16-bit word supplied on a port and repeated forever. A polarity input can flip the final stream. It is meant to feed a bit-serial transmit path under test, with a matching checker elsewhere.

All shift registers advance together on every enabled cycle, whichever mode is active. Reset, or any change of the mode input, reloads every register to its start state, so each mode always starts its stream from a known point and no register can settle into the all-zero state.

Top module: `prbs_pattern_gen`

## Requirements
- R1: Mode 3'b000 gives a 15-stage sequence: stage 1 takes the XOR of stages 14 and 15, and the output is the inverted stage 15; the stream repeats every 32767 bits, and its first bit after a reload is 0.
- R2: Mode 3'b001 gives a 20-stage sequence: stage 1 takes the XOR of stages 17 and 20, and the output is stage 20 uninverted; the first bit after a reload is 1.
- R3: Mode 3'b010 uses the 20-stage register of R2 but forces the output to 1 whenever stages 6 to 19 are all zero, so the stream never holds more than 14 zeros in a row.
- R4: Mode 3'b011 gives a 23-stage sequence: stage 1 takes the XOR of stages 18 and 23, and the output is stage 23 uninverted.
- R5: Mode 3'b100 alternates 1, 0, 1, 0 starting with 1 after a reload.
- R6: Mode 3'b101 gives a constant 1.
- R7: Mode 3'b110 sends the 16-bit user word most significant bit first, going from bit 0 back to bit 15 without a gap.
- R8: Mode 3'b111 gives a constant 0.
- R9: When the polarity input is 1 the output is the complement of the stream the mode would otherwise give; when it is 0 the stream passes unchanged.
- R10: A synchronous reset, or a mode value that differs from the one seen on the previous clock, loads every shift register with all ones, the alternating bit with 1 and the user bit index with 15; the first output bit after that edge follows from this start state.
- R11: On a clock where enable is low and the mode is unchanged, no state advances and the output holds while its inputs hold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| en | input | 1 | Advance the stream by one bit on this clock |
| mode | input | 3 | Pattern select |
| user_word | input | 16 | Word repeated in mode 3'b110 |
| invert | input | 1 | Complement the output stream |
| dout | output | 1 | Serial test bit |

## Verification
On every cycle the assertions check that a held enable freezes the output, that the 20-stage register shifts by one stage per enabled cycle, that any mode change lands the registers in the all-ones state, that the alternating mode flips each bit, and that the zero-limited mode never exceeds 14 zeros in a row. The exact bit order of each sequence, the 32767-bit period of the shortest one, the user-word wrap, and the polarity flip can only be shown by the bench comparing long output runs against its own sequence model.

// File: rtl/prbs_pattern_gen.sv
module prbs_pattern_gen #(
  parameter int USER_W = 16,
  localparam int IDX_W = $clog2(USER_W)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              en,
  input  logic [2:0]        mode,
  input  logic [USER_W-1:0] user_word,
  input  logic              invert,
  output logic              dout
);

  localparam logic [2:0] M_P15  = 3'b000;
  localparam logic [2:0] M_P20  = 3'b001;
  localparam logic [2:0] M_QRS  = 3'b010;
  localparam logic [2:0] M_P23  = 3'b011;
  localparam logic [2:0] M_ALT  = 3'b100;
  localparam logic [2:0] M_ONES = 3'b101;
  localparam logic [2:0] M_USR  = 3'b110;

  logic [14:0]      sr15;
  logic [19:0]      sr20;
  logic [22:0]      sr23;
  logic             alt_bit;
  logic [IDX_W-1:0] uidx;
  logic [2:0]       mode_q;
  logic             reload;
  logic             raw;

  assign reload = rst || (mode != mode_q);

  always_ff @(posedge clk) begin
    mode_q <= mode;
    if (reload) begin
      sr15    <= '1;
      sr20    <= '1;
      sr23    <= '1;
      alt_bit <= 1'b1;
      uidx    <= IDX_W'(USER_W - 1);
    end else if (en) begin
      sr15    <= {sr15[13:0], sr15[13] ^ sr15[14]};
      sr20    <= {sr20[18:0], sr20[16] ^ sr20[19]};
      sr23    <= {sr23[21:0], sr23[17] ^ sr23[22]};
      alt_bit <= ~alt_bit;
      uidx    <= (uidx == '0) ? IDX_W'(USER_W - 1) : uidx - 1'b1;
    end
  end

  always_comb begin
    case (mode)
      M_P15:   raw = ~sr15[14];
      M_P20:   raw = sr20[19];
      M_QRS:   raw = sr20[19] | (sr20[18:5] == '0);
      M_P23:   raw = sr23[22];
      M_ALT:   raw = alt_bit;
      M_ONES:  raw = 1'b1;
      M_USR:   raw = user_word[uidx];
      default: raw = 1'b0;
    endcase
  end

  assign dout = raw ^ invert;

  logic [4:0] zrun;
  always_ff @(posedge clk) begin
    if (reload || mode != M_QRS) zrun <= '0;
    else if (en) zrun <= raw ? 5'd0 : ((zrun == 5'd31) ? zrun : zrun + 5'd1);
  end

  // R11
  hold_when_idle_chk: assert property (@(posedge clk) disable iff (rst)
    (!en && mode == mode_q) |=>
      (!$stable(mode) || !$stable(invert) || !$stable(user_word) || $stable(dout)));

  // R2
  shift_by_one_chk: assert property (@(posedge clk) disable iff (rst)
    (en && mode == mode_q) |=> (sr20[19:1] == $past(sr20[18:0])));

  // R10
  reload_all_ones_chk: assert property (@(posedge clk) disable iff (rst)
    (mode != mode_q) |=> (&sr15 && &sr20 && &sr23 && alt_bit));

  // R5
  alt_toggles_chk: assert property (@(posedge clk) disable iff (rst)
    (en && mode == M_ALT && mode_q == M_ALT) |=>
      (!$stable(mode) || !$stable(invert) || (dout != $past(dout))));

  // R3
  zero_run_limit_chk: assert property (@(posedge clk) disable iff (rst)
    zrun <= 5'd14);

endmodule

// File: tb/tb_prbs_pattern_gen.sv
module tb_prbs_pattern_gen;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic en = 1'b1;
  logic [2:0] mode = 3'b000;
  logic [15:0] user_word = 16'h0000;
  logic invert = 1'b0;
  logic dout;

  int n_run = 0;
  int n_fail = 0;
  bit done = 0;

  always #10 clk = ~clk;

  prbs_pattern_gen dut (.clk(clk), .rst(rst), .en(en), .mode(mode),
                        .user_word(user_word), .invert(invert), .dout(dout));

  // stimulus table: {mode, invert, user_word}
  localparam logic [19:0] VEC [10] = '{
    {3'b000, 1'b0, 16'h0000},
    {3'b001, 1'b0, 16'h0000},
    {3'b010, 1'b0, 16'h0000},
    {3'b011, 1'b0, 16'h0000},
    {3'b100, 1'b0, 16'h0000},
    {3'b101, 1'b0, 16'h0000},
    {3'b110, 1'b0, 16'hA5C3},
    {3'b111, 1'b0, 16'h0000},
    {3'b001, 1'b1, 16'h0000},
    {3'b110, 1'b1, 16'h8001}
  };

  logic [14:0] m15;
  logic [19:0] m20;
  logic [22:0] m23;
  logic        malt;
  int          midx;

  task automatic m_load();
    m15 = '1; m20 = '1; m23 = '1; malt = 1'b1; midx = 15;
  endtask

  task automatic m_step();
    m15 = {m15[13:0], m15[13] ^ m15[14]};
    m20 = {m20[18:0], m20[16] ^ m20[19]};
    m23 = {m23[21:0], m23[17] ^ m23[22]};
    malt = ~malt;
    midx = (midx == 0) ? 15 : midx - 1;
  endtask

  function automatic logic m_bit(input logic [2:0] md, input logic inv, input logic [15:0] uw);
    logic b;
    case (md)
      3'b000: b = ~m15[14];
      3'b001: b = m20[19];
      3'b010: b = m20[19] | (m20[18:5] == 14'd0);
      3'b011: b = m23[22];
      3'b100: b = malt;
      3'b101: b = 1'b1;
      3'b110: b = uw[midx];
      default: b = 1'b0;
    endcase
    return b ^ inv;
  endfunction

  function automatic string req_of(input logic [2:0] md, input logic inv);
    if (inv) return "R9";
    case (md)
      3'b000: return "R1";
      3'b001: return "R2";
      3'b010: return "R3";
      3'b011: return "R4";
      3'b100: return "R5";
      3'b101: return "R6";
      3'b110: return "R7";
      default: return "R8";
    endcase
  endfunction

  task automatic check(input string r, input logic act, input logic exp, input int k);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s bit %0d: actual %b expected %b", r, k, act, exp);
    end
  endtask

  task automatic start(input logic [2:0] md, input logic inv, input logic [15:0] uw);
    @(negedge clk);
    rst = 1'b1; en = 1'b1; mode = md; invert = inv; user_word = uw;
    @(negedge clk);
    rst = 1'b0;
    m_load();
  endtask

  task automatic stream(input string r, input int n);
    for (int k = 0; k < n; k++) begin
      check(r, dout, m_bit(mode, invert, user_word), k);
      m_step();
      @(negedge clk);
    end
  endtask

  initial begin
    logic [15:0] first;
    repeat (2) @(negedge clk);
    rst = 1'b0;
    m_load();
    // R10: state after reset, mode 000 first bit is 0
    check("R10", dout, 1'b0, 0);

    for (int v = 0; v < 10; v++) begin
      start(VEC[v][19:17], VEC[v][16], VEC[v][15:0]);
      stream(req_of(VEC[v][19:17], VEC[v][16]), 48);
    end

    // R2 / R10: first bits of each mode right after reload
    start(3'b001, 1'b0, 16'h0);
    check("R2", dout, 1'b1, 0);
    start(3'b100, 1'b0, 16'h0);
    check("R5", dout, 1'b1, 0);
    start(3'b111, 1'b1, 16'h0);
    check("R9", dout, 1'b1, 0);

    // R11: enable low holds the output and the state
    start(3'b001, 1'b0, 16'h0);
    stream("R11", 7);
    en = 1'b0;
    for (int k = 0; k < 5; k++) begin
      @(negedge clk);
      check("R11", dout, m_bit(mode, invert, user_word), k);
    end
    en = 1'b1;
    @(negedge clk);
    m_step();
    stream("R11", 20);

    // R10: mode change without reset reloads all registers
    start(3'b001, 1'b0, 16'h0);
    stream("R2", 13);
    mode = 3'b011;
    @(negedge clk);
    m_load();
    stream("R10", 40);

    // R7: word wrap across several repeats
    start(3'b110, 1'b0, 16'h0F31);
    stream("R7", 50);

    // R3: long run against the zero-limited model
    start(3'b010, 1'b0, 16'h0);
    begin
      int zr = 0;
      int zmax = 0;
      for (int k = 0; k < 100000; k++) begin
        check("R3", dout, m_bit(mode, invert, user_word), k);
        zr = dout ? 0 : zr + 1;
        if (zr > zmax) zmax = zr;
        m_step();
        @(negedge clk);
      end
      n_run++;
      if (zmax > 14) begin
        n_fail++;
        $display("FAIL R3 zero run: actual %0d expected <= 14", zmax);
      end
    end

    // R1: period of the 15-stage sequence is 32767
    start(3'b000, 1'b0, 16'h0);
    for (int k = 0; k < 32767 + 16; k++) begin
      if (k < 16) first[k] = dout;
      else if (k >= 32767) check("R1", dout, first[k - 32767], k);
      @(negedge clk);
    end

    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      n_run++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule